// File: doc/BRIEF.md
# Byte-Oriented SPI Master with Register Access and Dual FIFOs

This block is a serial peripheral master that a processor controls through a small byte-wide register window. The processor pushes outgoing bytes into a 32-deep transmit queue and pulls incoming bytes from a 32-deep receive queue. Both queues share one data address. A shift engine moves one byte at a time, most significant bit first, on the serial clock. The clock polarity, the clock phase and the clock rate are all programmable.

Writes to the transmit queue do not pace reception. Instead, software loads a byte count, and the engine then clocks in that many bytes while it sends a fill pattern. Software also drives chip select directly through two bits, one that asserts it and one that forces it off. A loopback mode feeds the outgoing line back into the receiver. If software writes data while chip select is off, the engine records a sticky abort condition and stops transmitting. Four status flags, each paired with its own enable bit, are combined into one registered interrupt line.

Top module: `spi_regmaster`

## Requirements
- R1: The status register at offset 0x08 reports live flags in bits 7..4 (bit 7 transmit empty, bit 6 transmit full, bit 5 receive empty, bit 4 receive full). Its bits 2..0 read back as written. After reset it reads 0xA0.
- R2: cs_n is driven low when bit 0 of offset 0x08 is 1 and bit 1 is 0. Otherwise it is high, which includes the state after reset.
- R3: A byte written to offset 0x00 while chip select is asserted is shifted out MSB first, as 16 serial-clock edges. Offset 0x10 bit 5 sets the idle clock level and bit 4 sets the phase: 0 samples on the first edge, 1 shifts on the first edge. Bytes shifted in during transmit-only traffic are discarded.
- R4: The transmit queue holds 32 bytes. A write while it is full is dropped, and the transmit-full flag stays set.
- R5: A nonzero value at offset 0x18 makes the engine clock in that many bytes while sending 0xFF, once the transmit queue is empty. The value decrements per received byte and reads back as the remainder. The engine pauses while the receive queue is full.
- R6: A read of offset 0x00 returns the oldest received byte and removes it. When the receive queue is empty, the read returns 0x00 and changes nothing.
- R7: When offset 0x10 bit 6 is set, the receiver samples the outgoing data line and ignores miso.
- R8: Bits 2..0 of offset 0x10 set the serial half-period to (bits[2:1] + 1) system clocks. The value 0x07 gives a full period of 8 clocks.
- R9: While offset 0x10 bit 7 is 1, both queues are held empty. After it is cleared, the status register reads transmit and receive empty.
- R10: irq is a registered copy of the OR over the four status flags, each ANDed with its enable in offset 0x20 bits 7..4 (same order as R1).
- R11: A data write while cs_n is high drops the byte and sets the abort flag at offset 0x20 bit 2. The flag stays set, and blocks transmission, until a 1 is written to that bit.
- R12: While no byte is in progress, sclk rests at the level selected by the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A queue pointer or count that goes wrong appears in the status byte on the next read. It also shows up as a missing, repeated or out-of-order byte, either at the slave model within one byte time or in the receive data within one byte time. A fault in the phase or edge counter corrupts the bit order of the very first byte, and it shows in the spacing between the final two clock edges. An error in the receive counter or the abort latch appears when offset 0x18 or 0x20 is read back, and as bytes that appear or fail to appear after the expected number of byte times.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_DATA  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTL1  = 6'h08;
  localparam logic [ADDR_W-1:0] A_CTL2  = 6'h10;
  localparam logic [ADDR_W-1:0] A_RXCNT = 6'h18;
  localparam logic [ADDR_W-1:0] A_IEN   = 6'h20;
  // control-2 bit positions
  localparam int C2_QRST = 7;
  localparam int C2_LOOP = 6;
  localparam int C2_CPOL = 5;
  localparam int C2_CPHA = 4;
  // interrupt register abort bit
  localparam int IEN_ABORT = 2;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int BW = 8,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] tx_byte,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          loop,
  input  logic [HW-1:0] half,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] rx_byte,
  output logic          sclk,
  output logic          mosi
);
  localparam int EW = $clog2(2*BW);
  localparam logic [EW-1:0] LAST = EW'(2*BW-1);

  logic          busy_q, busy_d, done_q, done_d, sclk_q, sclk_d, cph_q, cph_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [HW-1:0] div_q, div_d, half_q, half_d;
  logic [BW-1:0] tsr_q, tsr_d, rsr_q, rsr_d;
  logic          sin;

  assign sin     = loop ? tsr_q[BW-1] : miso;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rsr_q;
  assign sclk    = sclk_q;
  assign mosi    = tsr_q[BW-1];

  always_comb begin
    busy_d = busy_q; done_d = 1'b0; sclk_d = sclk_q; cph_d = cph_q;
    edge_d = edge_q; div_d = div_q; half_d = half_q;
    tsr_d  = tsr_q;  rsr_d = rsr_q;
    if (!busy_q) begin
      sclk_d = cpol;
      if (start) begin
        busy_d = 1'b1;
        edge_d = '0;
        div_d  = '0;
        half_d = half;
        cph_d  = cpha;
        tsr_d  = tx_byte;
      end
    end else if (div_q == half_q - 1'b1) begin
      div_d  = '0;
      sclk_d = ~sclk_q;
      edge_d = edge_q + 1'b1;
      if (edge_q[0] == cph_q)  rsr_d = {rsr_q[BW-2:0], sin};
      else if (edge_q != '0)   tsr_d = {tsr_q[BW-2:0], 1'b0};
      if (edge_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0; cph_q <= 1'b0;
      edge_q <= '0;   div_q  <= '0;   half_q <= '0;
      tsr_q  <= '0;   rsr_q  <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; sclk_q <= sclk_d; cph_q <= cph_d;
      edge_q <= edge_d; div_q  <= div_d;  half_q <= half_d;
      tsr_q  <= tsr_d;  rsr_q  <= rsr_d;
    end
  end

  p_byte_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(edge_q) == LAST);
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spim_pkg::*;
#(
  parameter int         FIFO_DEPTH = 32,
  parameter int         DIV_W      = 3,
  parameter logic [7:0] FILL       = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic [2:0] c1_q, c1_d;
  logic [7:0] c2_q, c2_d, rxcnt_q, rxcnt_d;
  logic [3:0] ien_q, ien_d, flags;
  logic       abort_q, abort_d, job_q, job_d, irq_q, cs_n_q;
  logic       bus_wen, wr_data, rd_data, wr_bad;
  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_dout, rx_dout, sh_rx;
  logic       sh_busy, sh_done, start_tx, start_rx, tx_pop, rx_push, qrst;
  logic [DIV_W-1:0] half;

  assign bus_wen = bus_sel & bus_wr;
  assign wr_data = bus_wen & (bus_addr == A_DATA);
  assign rd_data = bus_sel & ~bus_wr & (bus_addr == A_DATA);
  assign wr_bad  = wr_data & cs_n_q;
  assign qrst    = c2_q[C2_QRST];
  assign flags   = {tx_empty, tx_full, rx_empty, rx_full};
  assign half    = DIV_W'(c2_q[DIV_W-1:1]) + 1'b1;

  assign start_tx = ~sh_busy & ~sh_done & ~cs_n_q & ~qrst & ~abort_q & ~tx_empty;
  assign start_rx = ~sh_busy & ~sh_done & ~cs_n_q & ~qrst & tx_empty &
                    (rxcnt_q != 8'd0) & ~rx_full;
  assign tx_pop   = start_tx;
  assign rx_push  = sh_done & job_q;

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(qrst), .push(wr_data & ~cs_n_q),
    .din(bus_wdata), .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(qrst), .push(rx_push), .din(sh_rx),
    .pop(rd_data), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  spim_shift #(.BW(8), .HW(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_tx | start_rx),
    .tx_byte(start_tx ? tx_dout : FILL), .cpol(c2_q[C2_CPOL]), .cpha(c2_q[C2_CPHA]),
    .loop(c2_q[C2_LOOP]), .half(half), .miso(miso), .busy(sh_busy), .done(sh_done),
    .rx_byte(sh_rx), .sclk(sclk), .mosi(mosi));

  always_comb begin
    c1_d = c1_q; c2_d = c2_q; rxcnt_d = rxcnt_q; ien_d = ien_q;
    abort_d = abort_q; job_d = job_q;
    if (rx_push && rxcnt_q != 8'd0) rxcnt_d = rxcnt_q - 8'd1;
    if (start_tx)      job_d = 1'b0;
    else if (start_rx) job_d = 1'b1;
    if (wr_bad) abort_d = 1'b1;
    if (bus_wen) begin
      case (bus_addr)
        A_CTL1:  c1_d = bus_wdata[2:0];
        A_CTL2:  c2_d = bus_wdata;
        A_RXCNT: rxcnt_d = bus_wdata;
        A_IEN: begin
          ien_d = bus_wdata[7:4];
          if (bus_wdata[IEN_ABORT]) abort_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_empty ? 8'h00 : rx_dout;
      A_CTL1:  bus_rdata = {flags, 1'b0, c1_q};
      A_CTL2:  bus_rdata = c2_q;
      A_RXCNT: bus_rdata = rxcnt_q;
      A_IEN:   bus_rdata = {ien_q, 1'b0, abort_q, 2'b00};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= '0; c2_q <= '0; rxcnt_q <= '0; ien_q <= '0;
      abort_q <= 1'b0; job_q <= 1'b0; irq_q <= 1'b0; cs_n_q <= 1'b1;
    end else begin
      c1_q <= c1_d; c2_q <= c2_d; rxcnt_q <= rxcnt_d; ien_q <= ien_d;
      abort_q <= abort_d; job_q <= job_d;
      irq_q  <= |(flags & ien_q);
      cs_n_q <= ~(c1_q[0] & ~c1_q[1]);
    end
  end

  assign irq  = irq_q;
  assign cs_n = cs_n_q;

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|({tx_empty, tx_full, rx_empty, rx_full} & ien_q)));
  p_rxcnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rxcnt_q != 8'd0 && !(bus_wen && bus_addr == A_RXCNT))
      |=> rxcnt_q == $past(rxcnt_q) - 8'd1);
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !(bus_wen && bus_addr == A_IEN && bus_wdata[IEN_ABORT])) |=> abort_q);
  p_txfull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_pop && !qrst) |=> tx_full);
endmodule

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sclk, mosi, miso, cs_n;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spi_regmaster u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  // slave model: mode taken from bench variables
  logic       s_cpha = 1'b0, s_prev = 1'b0;
  logic [7:0] s_out = 8'h00, s_sr = 8'h00, s_in = 8'h00;
  logic [7:0] cap [64];
  int         cap_n = 0, s_e = 0;
  time        t_prev = 0, t_last = 0;

  assign miso = s_sr[7];

  always @(sclk or cs_n) begin
    if (cs_n) begin
      s_e = 0; s_sr = s_out;
    end else if (sclk !== s_prev) begin
      t_prev = t_last; t_last = $time;
      if ((s_e % 2) == int'(s_cpha)) s_in = {s_in[6:0], mosi};
      else if (s_e != 0)             s_sr = {s_sr[6:0], 1'b0};
      if (s_e == 15) begin
        if (cap_n < 64) cap[cap_n] = s_in;
        cap_n = cap_n + 1;
        s_e = 0; s_sr = s_out;
      end else s_e = s_e + 1;
    end
    s_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {ctl2, tx byte, slave byte, unused}
  localparam logic [31:0] VEC [4] = '{32'h07A55A00, 32'h103CC300, 32'h23811800, 32'h357EE700};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int h;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    rd(8'h08, r); chk(r == 8'hA0, "R1 reset status", r, 8'hA0);
    chk(cs_n == 1'b1, "R2 reset cs_n", cs_n, 1);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    chk(sclk == 1'b0, "R12 reset sclk", sclk, 0);

    // vector table: mode, divider, tx byte, slave byte
    foreach (VEC[i]) begin
      wr(6'h08, 8'h02); idle(2);
      wr(6'h10, VEC[i][31:24]);
      s_cpha = VEC[i][28]; s_out = VEC[i][15:8];
      idle(2);
      chk(sclk == VEC[i][29], "R12 idle level", sclk, VEC[i][29]);
      wr(6'h08, 8'h01); idle(2);
      chk(cs_n == 1'b0, "R2 cs asserted", cs_n, 0);
      cap_n = 0;
      wr(6'h00, VEC[i][23:16]); idle(80);
      chk(cap_n == 1 && cap[0] == VEC[i][23:16], "R3 tx byte", cap[0], VEC[i][23:16]);
      h = int'(VEC[i][26:25]) + 1;
      chk((t_last - t_prev) == time'(h * 10), "R8 half period", int'(t_last - t_prev), h * 10);
      wr(6'h18, 8'h01); idle(80);
      rd(6'h00, r); chk(r == VEC[i][15:8], "R5 rx byte", r, VEC[i][15:8]);
      rd(6'h18, r); chk(r == 8'h00, "R5 count done", r, 0);
    end

    // chip select forced off by deassert bit
    wr(6'h08, 8'h03); idle(2);
    chk(cs_n == 1'b1, "R2 deassert wins", cs_n, 1);

    // transmit queue overflow, mode 0 slowest clock
    wr(6'h10, 8'h07); s_cpha = 1'b0; idle(2);
    wr(6'h08, 8'h01); idle(2);
    cap_n = 0;
    for (int k = 0; k < 34; k++) wr(6'h00, 8'(k));
    rd(6'h08, r); chk((r & 8'hF0) == 8'h60, "R4 tx full flag", r, 8'h61);
    idle(33 * 64 + 100);
    chk(cap_n == 33, "R4 byte count", cap_n, 33);
    chk(cap[32] == 8'd32 && cap[0] == 8'd0, "R4 order", cap[32], 32);

    // counted reception in loopback, slave drives zeros
    s_out = 8'h00;
    wr(6'h08, 8'h02); idle(2);
    wr(6'h10, 8'h47); idle(2);
    wr(6'h08, 8'h01); idle(2);
    wr(6'h18, 8'd40); idle(40 * 64 + 200);
    rd(6'h18, r); chk(r == 8'd8, "R5 remainder", r, 8);
    rd(6'h08, r); chk((r & 8'hF0) == 8'h90, "R5 rx full", r, 8'h91);
    rd(6'h00, r); chk(r == 8'hFF, "R7 loopback fill", r, 8'hFF);
    wr(6'h18, 8'h00); idle(100);
    wr(6'h10, 8'hC7); wr(6'h10, 8'h47); idle(2);
    rd(6'h08, r); chk((r & 8'hF0) == 8'hA0, "R9 queues cleared", r, 8'hA1);
    rd(6'h00, r); chk(r == 8'h00, "R6 empty read", r, 0);
    rd(6'h08, r); chk((r & 8'hF0) == 8'hA0, "R6 empty unchanged", r, 8'hA1);

    // abort on write with chip select off
    wr(6'h08, 8'h02); idle(2);
    cap_n = 0;
    wr(6'h00, 8'h55); idle(40);
    rd(6'h20, r); chk(r == 8'h04, "R11 abort set", r, 4);
    rd(6'h08, r); chk(r == 8'hA2, "R11 byte dropped", r, 8'hA2);
    wr(6'h08, 8'h01); idle(80);
    chk(cap_n == 0, "R11 no traffic", cap_n, 0);
    rd(6'h20, r); chk(r == 8'h04, "R11 sticky", r, 4);
    wr(6'h20, 8'h04); idle(1);
    rd(6'h20, r); chk(r == 8'h00, "R11 cleared", r, 0);

    // interrupt enables
    wr(6'h20, 8'h80); idle(2);
    chk(irq == 1'b1, "R10 tx empty irq", irq, 1);
    wr(6'h20, 8'h10); idle(2);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    wr(6'h20, 8'h20); idle(2);
    chk(irq == 1'b1, "R10 rx empty irq", irq, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule